// File: doc/BRIEF.md
# Call Gate Stack Switch Unit

This unit carries out the control-transfer part of a far call made through an 8-byte gate descriptor. It takes the raw descriptor, the caller's privilege level, the caller's CS, SS:ESP and return EIP, the privilege level of the target code segment and the base address of the current task state segment. A start pulse begins the transfer. The unit checks the descriptor and, if it accepts it, reports the new CS:EIP and SS:ESP together with a one-cycle done pulse. If it rejects the descriptor, it raises a fault code on the done pulse instead.

When the target level is numerically lower than the caller's level, the call goes inward. The unit then reads the inner stack pointer for the target level from the task state segment and saves the caller's stack pointer on the new stack. It copies the parameter doublewords named by the gate from the outer stack, and then pushes the return address. When the target level is equal to or outer than the caller's level, only the return address is pushed, on the current stack. All stack and task-state-segment traffic goes through a single 32-bit request/acknowledge memory port, one word per access.

Top module: `cgate_stack_switch`

## Requirements
- R1: On success, new EIP equals {gate[63:48], gate[15:0]} and new CS equals {gate[31:18], target level}.
- R2: The gate is rejected with fault code 1 (bad type) if bit 44 is 1, if bits 43:40 differ from 4'hC, or if bits 39:37 are non-zero. Such a gate makes no memory access.
- R3: A caller level greater than the gate DPL (bits 46:45) gives fault code 2. This happens before any memory access, and the check takes priority over the present check.
- R4: A gate whose present bit (bit 47) is 0 gives fault code 3. The order of precedence is bad type, then privilege, then not present.
- R5: On an inward call (target < caller), ESP is read from tss_base + 4 + 8*target and SS from the low 16 bits of the next word. These values become the start of the new stack, and new SS is taken from that second word.
- R6: On an inward call, the pushes go in this order, each one 4 bytes below the last: old SS zero-extended, old ESP, parameters, old CS zero-extended, return EIP. New ESP is the slot ESP minus 4*(4+n).
- R7: The parameter count n is gate bits 36:32 (0 to 31). Parameters are read from the outer stack starting with the highest address, cur_esp + 4*(n-1), and ending with cur_esp.
- R8: When the target level is not below the caller's level, there is no stack switch and the count is ignored. CS and EIP are pushed on the current stack, new SS is cur_ss and new ESP is cur_esp - 8.
- R9: An inward call makes exactly 6 + 2n accepted memory accesses, and a call with no switch makes exactly 2. The task state segment is never written.
- R10: While mem_req is high and mem_ack is low, the request, address, write enable and write data stay unchanged. mem_we is high only while mem_req is high.
- R11: done is a one-cycle pulse. fault is high only together with done. fault_code is 0 on success and non-zero on a fault.
- R12: A start pulse that arrives while a transfer is in progress is ignored.
- R13: During and right after reset, done, fault and mem_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer; all context inputs are sampled on this cycle |
| gate_desc | input | 64 | Raw gate descriptor |
| cpl | input | 2 | Caller privilege level |
| tgt_dpl | input | 2 | Privilege level of the target code segment |
| cur_cs | input | 16 | Caller code selector |
| cur_ss | input | 16 | Caller stack selector |
| cur_esp | input | 32 | Caller stack pointer |
| ret_eip | input | 32 | Return address to push |
| tss_base | input | 32 | Base address of the current task state segment |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Transfer rejected (with done) |
| fault_code | output | 2 | 0 none, 1 bad type, 2 privilege, 3 not present |
| new_cs | output | 16 | Target code selector |
| new_eip | output | 32 | Target entry offset |
| new_ss | output | 16 | Stack selector after transfer |
| new_esp | output | 32 | Stack pointer after transfer |

## Verification
A wrong sequencer state shows up at the memory port on the very next accepted access. The symptom is a misplaced address, a write where a read belongs, or an access count that is off. A pointer error shows up on the stack image and on new_esp at the done pulse. A decode fault routed down the wrong path shows up at done as the wrong fault code, or as memory traffic that should not occur. Stalled acknowledges expose any request that drifts while it waits, and they do so within one cycle of the drift.

// File: rtl/cgss_pkg.sv
// Package: shared types for the call gate stack switch unit.
// Assumes 32-bit addresses and the fixed 8-byte gate layout.
package cgss_pkg;

    localparam logic [3:0] CALL_GATE32 = 4'hC;
    localparam int         CNT_W       = 5;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_TYPE   = 2'd1,
        FLT_PRIV   = 2'd2,
        FLT_ABSENT = 2'd3
    } fault_e;

    typedef struct packed {
        logic [31:0]      offset;
        logic [13:0]      sel_idx;
        logic [CNT_W-1:0] cnt;
    } gate_info_t;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_TSS_SP, S_TSS_SEL, S_PUSH_SEL, S_PUSH_SP,
        S_ARG_RD, S_ARG_WR, S_PUSH_CS, S_PUSH_IP
    } xfer_state_e;

endpackage

// File: rtl/cgss_gate_decode.sv
// Gate decoder: splits the raw descriptor into its fields and ranks the
// rejection reasons. Purely combinational; assumes inputs are already latched.
module cgss_gate_decode
    import cgss_pkg::*;
(
    input  logic [63:0] gate,
    input  logic [1:0]  cpl,
    input  logic [1:0]  tgt_dpl,
    output gate_info_t  info,
    output fault_e      flt,
    output logic        inward
);
    logic       present;
    logic [1:0] gdpl;
    logic       dt_bit;
    logic [3:0] gtype;
    logic [2:0] rsv;
    logic       unused_rpl;

    // Field extraction from the fixed byte layout.
    always_comb begin
        info.offset  = {gate[63:48], gate[15:0]};
        info.sel_idx = gate[31:18];
        info.cnt     = gate[32 +: CNT_W];
        rsv          = gate[39:37];
        present      = gate[47];
        gdpl         = gate[46:45];
        dt_bit       = gate[44];
        gtype        = gate[43:40];
    end

    // The requested selector RPL is replaced by the target level.
    assign unused_rpl = ^gate[17:16];

    // Rejection ranking: type, then privilege, then presence.
    always_comb begin
        if (dt_bit || gtype != CALL_GATE32 || rsv != 3'b000)
            flt = FLT_TYPE;
        else if (cpl > gdpl)
            flt = FLT_PRIV;
        else if (!present)
            flt = FLT_ABSENT;
        else
            flt = FLT_NONE;
    end

    // Stack switch only when moving to a more privileged level.
    assign inward = (tgt_dpl < cpl);

endmodule

// File: rtl/cgss_xfer_seq.sv
// Transfer sequencer: latches the call context, drives the word-wide memory
// port through the TSS read, the pushes and the parameter copy, and
// registers the results. Assumes the memory holds a request until mem_ack.
module cgss_xfer_seq
    import cgss_pkg::*;
#(
    parameter int TSS_SLOT0  = 4,
    parameter int TSS_STRIDE = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] gate_desc,
    input  logic [1:0]  cpl,
    input  logic [1:0]  tgt_dpl,
    input  logic [15:0] cur_cs,
    input  logic [15:0] cur_ss,
    input  logic [31:0] cur_esp,
    input  logic [31:0] ret_eip,
    input  logic [31:0] tss_base,
    output logic [63:0] gate_q,
    output logic [1:0]  cpl_q,
    output logic [1:0]  tgt_q,
    input  gate_info_t  info,
    input  fault_e      flt,
    input  logic        inward,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        done,
    output logic        fault,
    output fault_e      fault_code,
    output logic [15:0] new_cs,
    output logic [31:0] new_eip,
    output logic [15:0] new_ss,
    output logic [31:0] new_esp
);
    localparam int          STRIDE_SH = $clog2(TSS_STRIDE);
    localparam int          WSH       = $clog2(WORD_BYTES);
    localparam logic [31:0] WSTEP     = 32'(WORD_BYTES);

    xfer_state_e      state;
    logic [15:0]      cs_q, ss_q, nss_q;
    logic [31:0]      esp_q, eip_q, base_q;
    logic [31:0]      sp_q, src_q, arg_q;
    logic [CNT_W-1:0] left_q;
    logic [31:0]      slot_addr;

    assign slot_addr = base_q + 32'(TSS_SLOT0) + (32'(tgt_q) << STRIDE_SH);

    // Memory port request decode per state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - WSTEP;
        mem_wdata = 32'h0;
        case (state)
            S_TSS_SP:   begin mem_we = 1'b0; mem_addr = slot_addr; end
            S_TSS_SEL:  begin mem_we = 1'b0; mem_addr = slot_addr + WSTEP; end
            S_PUSH_SEL: mem_wdata = {16'h0, ss_q};
            S_PUSH_SP:  mem_wdata = esp_q;
            S_ARG_RD:   begin mem_we = 1'b0; mem_addr = src_q; end
            S_ARG_WR:   mem_wdata = arg_q;
            S_PUSH_CS:  mem_wdata = {16'h0, cs_q};
            S_PUSH_IP:  mem_wdata = eip_q;
            default:    begin mem_req = 1'b0; mem_we = 1'b0; end
        endcase
    end

    // Sequencer state, working pointers and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_code <= FLT_NONE;
            gate_q     <= '0;
            cpl_q      <= '0;
            tgt_q      <= '0;
            cs_q       <= '0;
            ss_q       <= '0;
            nss_q      <= '0;
            esp_q      <= '0;
            eip_q      <= '0;
            base_q     <= '0;
            sp_q       <= '0;
            src_q      <= '0;
            arg_q      <= '0;
            left_q     <= '0;
            new_cs     <= '0;
            new_eip    <= '0;
            new_ss     <= '0;
            new_esp    <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    gate_q <= gate_desc;
                    cpl_q  <= cpl;
                    tgt_q  <= tgt_dpl;
                    cs_q   <= cur_cs;
                    ss_q   <= cur_ss;
                    esp_q  <= cur_esp;
                    eip_q  <= ret_eip;
                    base_q <= tss_base;
                    state  <= S_CHECK;
                end
                S_CHECK: begin
                    if (flt != FLT_NONE) begin
                        done       <= 1'b1;
                        fault      <= 1'b1;
                        fault_code <= flt;
                        state      <= S_IDLE;
                    end else if (inward) begin
                        left_q <= info.cnt;
                        src_q  <= esp_q + (32'(info.cnt) << WSH) - WSTEP;
                        state  <= S_TSS_SP;
                    end else begin
                        sp_q  <= esp_q;
                        nss_q <= ss_q;
                        state <= S_PUSH_CS;
                    end
                end
                S_TSS_SP: if (mem_ack) begin
                    sp_q  <= mem_rdata;
                    state <= S_TSS_SEL;
                end
                S_TSS_SEL: if (mem_ack) begin
                    nss_q <= mem_rdata[15:0];
                    state <= S_PUSH_SEL;
                end
                S_PUSH_SEL: if (mem_ack) begin
                    sp_q  <= sp_q - WSTEP;
                    state <= S_PUSH_SP;
                end
                S_PUSH_SP: if (mem_ack) begin
                    sp_q  <= sp_q - WSTEP;
                    state <= (left_q != '0) ? S_ARG_RD : S_PUSH_CS;
                end
                S_ARG_RD: if (mem_ack) begin
                    arg_q <= mem_rdata;
                    src_q <= src_q - WSTEP;
                    state <= S_ARG_WR;
                end
                S_ARG_WR: if (mem_ack) begin
                    sp_q   <= sp_q - WSTEP;
                    left_q <= left_q - 1'b1;
                    state  <= (left_q == CNT_W'(1)) ? S_PUSH_CS : S_ARG_RD;
                end
                S_PUSH_CS: if (mem_ack) begin
                    sp_q  <= sp_q - WSTEP;
                    state <= S_PUSH_IP;
                end
                S_PUSH_IP: if (mem_ack) begin
                    new_esp    <= sp_q - WSTEP;
                    new_ss     <= nss_q;
                    new_cs     <= {info.sel_idx, tgt_q};
                    new_eip    <= info.offset;
                    fault_code <= FLT_NONE;
                    done       <= 1'b1;
                    state      <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cgate_stack_switch.sv
// Top of the call gate stack switch unit: joins the gate decoder to the
// transfer sequencer. Assumes one transfer at a time, started by a pulse.
module cgate_stack_switch
    import cgss_pkg::*;
#(
    parameter int TSS_SLOT0  = 4,
    parameter int TSS_STRIDE = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] gate_desc,
    input  logic [1:0]  cpl,
    input  logic [1:0]  tgt_dpl,
    input  logic [15:0] cur_cs,
    input  logic [15:0] cur_ss,
    input  logic [31:0] cur_esp,
    input  logic [31:0] ret_eip,
    input  logic [31:0] tss_base,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        done,
    output logic        fault,
    output logic [1:0]  fault_code,
    output logic [15:0] new_cs,
    output logic [31:0] new_eip,
    output logic [15:0] new_ss,
    output logic [31:0] new_esp
);
    logic [63:0] gate_q;
    logic [1:0]  cpl_q, tgt_q;
    gate_info_t  info;
    fault_e      flt, code_q;
    logic        inward;

    cgss_gate_decode u_dec (
        .gate    (gate_q),
        .cpl     (cpl_q),
        .tgt_dpl (tgt_q),
        .info    (info),
        .flt     (flt),
        .inward  (inward)
    );

    cgss_xfer_seq #(
        .TSS_SLOT0  (TSS_SLOT0),
        .TSS_STRIDE (TSS_STRIDE),
        .WORD_BYTES (WORD_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .gate_desc  (gate_desc),
        .cpl        (cpl),
        .tgt_dpl    (tgt_dpl),
        .cur_cs     (cur_cs),
        .cur_ss     (cur_ss),
        .cur_esp    (cur_esp),
        .ret_eip    (ret_eip),
        .tss_base   (tss_base),
        .gate_q     (gate_q),
        .cpl_q      (cpl_q),
        .tgt_q      (tgt_q),
        .info       (info),
        .flt        (flt),
        .inward     (inward),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .done       (done),
        .fault      (fault),
        .fault_code (code_q),
        .new_cs     (new_cs),
        .new_eip    (new_eip),
        .new_ss     (new_ss),
        .new_esp    (new_esp)
    );

    assign fault_code = code_q;

endmodule

// File: rtl/cgss_checker.sv
// Checker: port-level protocol properties of the call gate stack switch
// unit. Bound to the top; assumes synchronous active-low reset.
module cgss_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        done,
    input logic        fault,
    input logic [1:0]  fault_code
);
    logic seen_q;

    // Records any memory request since the previous completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    seen_q <= 1'b0;
        else if (done) seen_q <= 1'b0;
        else           seen_q <= seen_q | mem_req;
    end

    assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_we_in_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    assert_code_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault == (fault_code != 2'd0)));

    assert_no_access_on_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> !seen_q);

endmodule

bind cgate_stack_switch cgss_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code)
);

// File: tb/cgate_stack_switch_tb.sv
module cgate_stack_switch_tb;

    typedef struct packed {
        logic       p;
        logic [1:0] dpl;
        logic       dt;
        logic [3:0] typ;
        logic [2:0] rsv;
        logic [4:0] cnt;
        logic [1:0] cpl;
        logic [1:0] tgt;
        logic [1:0] code;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{1'b1, 2'd3, 1'b0, 4'hC, 3'd0, 5'd2,  2'd3, 2'd0, 2'd0},
        '{1'b1, 2'd3, 1'b0, 4'hC, 3'd0, 5'd0,  2'd3, 2'd1, 2'd0},
        '{1'b1, 2'd3, 1'b0, 4'hC, 3'd0, 5'd31, 2'd2, 2'd0, 2'd0},
        '{1'b1, 2'd0, 1'b0, 4'hC, 3'd0, 5'd5,  2'd0, 2'd0, 2'd0},
        '{1'b1, 2'd2, 1'b0, 4'hC, 3'd0, 5'd3,  2'd1, 2'd3, 2'd0},
        '{1'b1, 2'd3, 1'b0, 4'hC, 3'd0, 5'd1,  2'd3, 2'd2, 2'd0},
        '{1'b1, 2'd3, 1'b0, 4'h4, 3'd0, 5'd2,  2'd0, 2'd0, 2'd1},
        '{1'b1, 2'd3, 1'b0, 4'h9, 3'd0, 5'd2,  2'd3, 2'd0, 2'd1},
        '{1'b1, 2'd3, 1'b0, 4'h0, 3'd0, 5'd2,  2'd3, 2'd0, 2'd1},
        '{1'b1, 2'd3, 1'b1, 4'hC, 3'd0, 5'd2,  2'd3, 2'd0, 2'd1},
        '{1'b1, 2'd0, 1'b0, 4'hC, 3'd0, 5'd2,  2'd3, 2'd0, 2'd2},
        '{1'b0, 2'd3, 1'b0, 4'hC, 3'd0, 5'd2,  2'd3, 2'd0, 2'd3},
        '{1'b0, 2'd1, 1'b0, 4'hC, 3'd0, 5'd2,  2'd2, 2'd0, 2'd2},
        '{1'b0, 2'd3, 1'b0, 4'hD, 3'd0, 5'd0,  2'd3, 2'd0, 2'd1},
        '{1'b1, 2'd3, 1'b0, 4'hC, 3'd4, 5'd2,  2'd3, 2'd0, 2'd1}
    };

    localparam logic [31:0] TSS_BASE = 32'h100;
    localparam logic [31:0] OUT_ESP  = 32'h200;
    localparam logic [15:0] OUT_SS   = 16'h002B;
    localparam logic [15:0] OUT_CS   = 16'h001B;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [63:0] gate_desc;
    logic [1:0]  cpl, tgt_dpl;
    logic [31:0] ret_eip;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, fault;
    logic [1:0]  fault_code;
    logic [15:0] new_cs, new_ss;
    logic [31:0] new_eip, new_esp;

    logic [31:0] mem [0:255];
    logic        init_req = 1'b0;
    logic        stall = 1'b0;
    logic        ph = 1'b0;
    int          acc_cnt = 0;
    int          done_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    cgate_stack_switch u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gate_desc(gate_desc),
        .cpl(cpl), .tgt_dpl(tgt_dpl), .cur_cs(OUT_CS), .cur_ss(OUT_SS),
        .cur_esp(OUT_ESP), .ret_eip(ret_eip), .tss_base(TSS_BASE),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .done(done), .fault(fault), .fault_code(fault_code),
        .new_cs(new_cs), .new_eip(new_eip), .new_ss(new_ss), .new_esp(new_esp)
    );

    function automatic logic [31:0] slot_esp(int lvl);
        return 32'h3C0 - 32'(lvl) * 32'h40;
    endfunction

    function automatic logic [15:0] slot_ss(int lvl);
        return 16'h0010 + 16'(lvl) * 16'h8;
    endfunction

    function automatic logic [31:0] init_val(int w);
        if (w >= 'h41 && w <= 'h46) begin
            if (((w - 'h41) % 2) == 0) return slot_esp((w - 'h41) / 2);
            return {16'hBEEF, slot_ss((w - 'h42) / 2)};
        end
        if (w >= 'h80 && w < 'hA0) return 32'hA500_0000 + 32'(w);
        return 32'hDEAD_0000 + 32'(w);
    endfunction

    assign mem_ack   = mem_req && (!stall || ph);
    assign mem_rdata = mem[mem_addr[9:2]];

    // Memory model, access and completion counters.
    always @(posedge clk) begin
        ph <= ~ph;
        if (init_req) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else if (mem_req && mem_ack && mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
        end
        if (start) begin
            acc_cnt  <= 0;
            done_cnt <= 0;
        end else begin
            if (mem_req && mem_ack) acc_cnt <= acc_cnt + 1;
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    // Global watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_gate(vec_t v, int i);
        logic [31:0] off;
        logic [15:0] sel;
        off = 32'h1234_5600 + 32'(i);
        sel = 16'h0043 + 16'(i) * 16'h8;
        return {off[31:16], v.p, v.dpl, v.dt, v.typ, v.rsv, v.cnt, sel, off[15:0]};
    endfunction

    task automatic launch(input logic [63:0] g, input logic [1:0] c,
                          input logic [1:0] t, input int seed);
        @(negedge clk) init_req = 1'b1;
        @(negedge clk) init_req = 1'b0;
        gate_desc = g;
        cpl       = c;
        tgt_dpl   = t;
        ret_eip   = 32'h0040_1000 + 32'(seed);
        start     = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (!done) chk("R11", "timeout waiting for done", 32'(done), 32'd1);
    endtask

    task automatic verify(input vec_t v, input int i, input logic [63:0] g);
        int n;
        int bad_ix;
        logic [31:0] base, exp_w, got_w;
        chk("R11", "fault flag", 32'(fault), 32'(v.code != 2'd0));
        chk(v.code == 2'd1 ? "R2" : v.code == 2'd2 ? "R3" : v.code == 2'd3 ? "R4" : "R11",
            "fault code", 32'(fault_code), 32'(v.code));
        if (v.code != 2'd0) begin
            @(negedge clk);
            chk("R3", "accesses on fault", 32'(acc_cnt), 32'd0);
            return;
        end
        chk("R1", "new EIP", new_eip, {g[63:48], g[15:0]});
        chk("R1", "new CS", 32'(new_cs), 32'({g[31:18], v.tgt}));
        @(negedge clk);
        chk("R11", "done pulse width", 32'(done), 32'd0);
        if (v.tgt < v.cpl) begin
            n    = int'(v.cnt);
            base = slot_esp(int'(v.tgt));
            chk("R5", "new SS from TSS", 32'(new_ss), 32'(slot_ss(int'(v.tgt))));
            chk("R6", "new ESP", new_esp, base - 32'(4 * (4 + n)));
            chk("R9", "access count", 32'(acc_cnt), 32'(6 + 2 * n));
            bad_ix = -1;
            got_w = '0;
            exp_w = '0;
            for (int j = 0; j < 4 + n; j++) begin
                logic [31:0] e;
                if (j == 0)          e = {16'h0, OUT_SS};
                else if (j == 1)     e = OUT_ESP;
                else if (j < n + 2)  e = init_val(int'((OUT_ESP + 32'(4 * (n - 1 - (j - 2)))) >> 2));
                else if (j == n + 2) e = {16'h0, OUT_CS};
                else                 e = 32'h0040_1000 + 32'(i);
                if (bad_ix < 0 && mem[(base - 32'(4 * (j + 1))) >> 2] !== e) begin
                    bad_ix = j;
                    got_w  = mem[(base - 32'(4 * (j + 1))) >> 2];
                    exp_w  = e;
                end
            end
            chk(n > 0 ? "R7" : "R6", "inner stack image", got_w, exp_w);
        end else begin
            chk("R8", "new SS unchanged", 32'(new_ss), 32'(OUT_SS));
            chk("R8", "new ESP", new_esp, OUT_ESP - 32'd8);
            chk("R8", "pushed CS", mem[(OUT_ESP - 32'd4) >> 2], {16'h0, OUT_CS});
            chk("R8", "pushed EIP", mem[(OUT_ESP - 32'd8) >> 2], 32'h0040_1000 + 32'(i));
            chk("R9", "access count", 32'(acc_cnt), 32'd2);
        end
        for (int w = 'h41; w <= 'h46; w++)
            chk("R9", "TSS word untouched", mem[w], init_val(w));
    endtask

    initial begin
        rst_n     = 1'b0;
        start     = 1'b0;
        gate_desc = '0;
        cpl       = '0;
        tgt_dpl   = '0;
        ret_eip   = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R13", "done in reset", 32'(done), 32'd0);
        chk("R13", "fault in reset", 32'(fault), 32'd0);
        chk("R13", "mem_req in reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "mem_req after reset", 32'(mem_req), 32'd0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            logic [63:0] g;
            g = mk_gate(VT[i], i);
            launch(g, VT[i].cpl, VT[i].tgt, i);
            wait_done();
            verify(VT[i], i, g);
        end

        // R10: stalled acknowledges on an inward call with parameters.
        stall = 1'b1;
        begin
            logic [63:0] g;
            g = mk_gate(VT[2], 2);
            launch(g, VT[2].cpl, VT[2].tgt, 2);
            wait_done();
            verify(VT[2], 2, g);
        end
        stall = 1'b0;

        // R12: a second start while busy is ignored.
        begin
            logic [63:0] g;
            vec_t bad;
            g   = mk_gate(VT[0], 0);
            bad = VT[6];
            launch(g, VT[0].cpl, VT[0].tgt, 0);
            gate_desc = mk_gate(bad, 6);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            gate_desc = g;
            wait_done();
            chk("R12", "fault on busy start", 32'(fault), 32'd0);
            chk("R12", "EIP of first call", new_eip, {g[63:48], g[15:0]});
            chk("R12", "ESP of first call", new_esp, slot_esp(0) - 32'd24);
            repeat (30) @(negedge clk);
            chk("R12", "single completion", 32'(done_cnt), 32'd1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule